// File: doc/BRIEF.md
# Binary Pixel Chip Event Buffer

This block is the digital readout side of a binary hybrid pixel chip. The matrix has 32 columns of 256 pixels, and each pixel holds one hit bit. When a trigger strobe arrives, the block captures the full 8192-bit hit pattern into a small first-in first-out event buffer. The buffer is four events deep by default, and a parameter selects a different depth, such as five.

Several chips share one data bus. While its chip-select is high, a chip presents the oldest stored event one 32-bit word at a time. Bit c of a word is the pixel of column c, and the row index walks from 0 to 255. Each read strobe given with chip-select high moves to the next row. The 256th strobe frees the slot. The block adds no header, trailer, parity or event number, so the 256 words are the whole event. With chip-select low, the chip releases the bus: data is zero and valid is low. The busy, empty and overflow flags tell the trigger side and the bus master the state of the buffer.

Top module: `hitbuf_top`

## Requirements
- R1: After reset, empty_o is 1, and busy_o, ovf_o, valid_o and data_o are all 0.
- R2: A trigger strobe (trig_i high for one cycle) with a free slot stores hits_i. The pixel of column c and row r sits at hits_i bit index c*256 + r. In the word read for row r, bit c is that pixel.
- R3: Each cycle with cs_i and rd_i both high and an event stored moves the row index up by one at the next clock edge. data_o always shows the word for the current row index.
- R4: After the word for row 255 is read, the slot is freed and the row index returns to 0. The next stored event starts with its row-0 word, and each event is exactly 256 words with nothing added.
- R5: Events are read out in the order their triggers arrived.
- R6: busy_o is 1 exactly when every slot holds an event.
- R7: A trigger that arrives while busy_o is 1 is dropped. The stored events are unchanged and ovf_o goes to 1 and stays there until reset.
- R8: While cs_i is 0, data_o is 0 and valid_o is 0. A read strobe given without chip-select does not move the row index.
- R9: empty_o is 1 exactly when no event is stored. While it is 1, valid_o and data_o are 0 and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger strobe, captures hits_i |
| hits_i | input | 8192 | Hit pattern, bit c*256+r is column c, row r |
| cs_i | input | 1 | Chip-select for the shared bus |
| rd_i | input | 1 | Read strobe, consumes one word when selected |
| data_o | output | 32 | Current row word, one bit per column |
| valid_o | output | 1 | Selected and an event is available |
| busy_o | output | 1 | All slots full |
| empty_o | output | 1 | No event stored |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The bench uses several hit patterns, and each one separates a different fault:
- An all-zero pattern and an all-one pattern catch stuck output bits.
- A single hit pixel exposes any column/row transpose or index slip.
- Event-specific arithmetic patterns filling every slot expose wrong readout order and pointer wrap errors.
- A trigger sent while the buffer is full carries a distinct pattern, so the bench can prove it was not stored.
- A read paused with chip-select low partway through an event, and read strobes sent to an empty buffer, show that neither touches the row index.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;

    localparam int unsigned RING_W = 8;

    // Advance a ring index, wrapping after depth-1.
    function automatic logic [RING_W-1:0] ring_next(input logic [RING_W-1:0] p,
                                                    input int unsigned depth);
        if (32'(p) == depth - 1) return '0;
        return p + 8'd1;
    endfunction

endpackage

// File: rtl/hitbuf_ctrl.sv
module hitbuf_ctrl #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned N_ROWS = 256,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned ROW_W = $clog2(N_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             cs_i,
    input  logic             rd_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [ROW_W-1:0] row_o,
    output logic             busy_o,
    output logic             empty_o,
    output logic             ovf_o
);
    import hitbuf_pkg::*;

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic             ovf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  full, none, push, step, pop;

    always_comb begin
        full = (st_q.cnt == FULL_CNT);
        none = (st_q.cnt == '0);
        push = trig_i && !full;
        step = cs_i && rd_i && !none;
        pop  = step && (st_q.row == LAST_ROW);

        st_d = st_q;
        if (push) st_d.wr = PTR_W'(ring_next(RING_W'(st_q.wr), DEPTH));
        if (pop)  st_d.rd = PTR_W'(ring_next(RING_W'(st_q.rd), DEPTH));
        if (step) st_d.row = pop ? '0 : st_q.row + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
        if (trig_i && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o  = push;
    assign wr_ptr_o = st_q.wr;
    assign rd_ptr_o = st_q.rd;
    assign row_o    = st_q.row;
    assign busy_o   = full;
    assign empty_o  = none;
    assign ovf_o    = st_q.ovf;

endmodule

// File: rtl/hitbuf_store.sv
module hitbuf_store #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned N_COLS = 32,
    parameter int unsigned N_ROWS = 256,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned ROW_W = $clog2(N_ROWS),
    localparam int unsigned NPIX  = N_COLS * N_ROWS
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_ptr_i,
    input  logic [NPIX-1:0]   hits_i,
    input  logic [PTR_W-1:0]  rd_ptr_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic [N_COLS-1:0] word_o
);
    logic [N_COLS-1:0] mem_q  [DEPTH][N_ROWS];
    logic [N_COLS-1:0] word_d [N_ROWS];

    // Transpose column-major hits into row words.
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        for (genvar c = 0; c < N_COLS; c++) begin : g_col
            assign word_d[r][c] = hits_i[c*N_ROWS + r];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            for (int r = 0; r < N_ROWS; r++) mem_q[wr_ptr_i][r] <= word_d[r];
        end
    end

    assign word_o = mem_q[rd_ptr_i][row_i];

endmodule

// File: rtl/hitbuf_top.sv
module hitbuf_top #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned N_COLS = 32,
    parameter int unsigned N_ROWS = 256,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned ROW_W = $clog2(N_ROWS),
    localparam int unsigned NPIX  = N_COLS * N_ROWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [NPIX-1:0]   hits_i,
    input  logic              cs_i,
    input  logic              rd_i,
    output logic [N_COLS-1:0] data_o,
    output logic              valid_o,
    output logic              busy_o,
    output logic              empty_o,
    output logic              ovf_o
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [ROW_W-1:0] row_idx;
    logic [N_COLS-1:0] word;
    logic             drive;

    hitbuf_ctrl #(.DEPTH(DEPTH), .N_ROWS(N_ROWS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cs_i(cs_i), .rd_i(rd_i),
        .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .row_o(row_idx),
        .busy_o(busy_o), .empty_o(empty_o), .ovf_o(ovf_o)
    );

    hitbuf_store #(.DEPTH(DEPTH), .N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_store (
        .clk(clk), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr), .hits_i(hits_i),
        .rd_ptr_i(rd_ptr), .row_i(row_idx), .word_o(word)
    );

    assign drive   = cs_i && !empty_o;
    assign valid_o = drive;
    assign data_o  = drive ? word : '0;

endmodule

// File: rtl/hitbuf_chk.sv
module hitbuf_chk #(
    parameter int unsigned N_COLS = 32,
    parameter int unsigned N_ROWS = 256,
    localparam int unsigned ROW_W = $clog2(N_ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic              cs_i,
    input logic              rd_i,
    input logic [N_COLS-1:0] data_o,
    input logic              valid_o,
    input logic              busy_o,
    input logic              empty_o,
    input logic              ovf_o,
    input logic [ROW_W-1:0]  row_idx
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

    assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |-> (data_o == '0 && !valid_o));

    assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_i && rd_i) |=> $stable(row_idx));

    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (!valid_o && data_o == '0));

    assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !empty_o);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> ovf_o);

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && rd_i && !empty_o && row_idx != LAST_ROW) |=>
            row_idx == ROW_W'($past(row_idx) + 1'b1));

    assert_row_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && rd_i && !empty_o && row_idx == LAST_ROW) |=> row_idx == '0);

endmodule

bind hitbuf_top hitbuf_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cs_i(cs_i), .rd_i(rd_i),
    .data_o(data_o), .valid_o(valid_o), .busy_o(busy_o), .empty_o(empty_o),
    .ovf_o(ovf_o), .row_idx(row_idx)
);

// File: tb/hitbuf_top_bench.sv
module hitbuf_top_bench;
    localparam int unsigned DEPTH  = 4;
    localparam int unsigned N_COLS = 32;
    localparam int unsigned N_ROWS = 256;
    localparam int unsigned NPIX   = N_COLS * N_ROWS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_i = 1'b0;
    logic [NPIX-1:0]   hits_i = '0;
    logic              cs_i = 1'b0;
    logic              rd_i = 1'b0;
    logic [N_COLS-1:0] data_o;
    logic              valid_o, busy_o, empty_o, ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hitbuf_top #(.DEPTH(DEPTH), .N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_hitbuf_top (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .hits_i(hits_i),
        .cs_i(cs_i), .rd_i(rd_i), .data_o(data_o), .valid_o(valid_o),
        .busy_o(busy_o), .empty_o(empty_o), .ovf_o(ovf_o)
    );

    // Pattern k: 0 all clear, 1 all set, 2 one pixel (col 17, row 200), else arithmetic.
    function automatic bit pat(input int k, input int c, input int r);
        if (k == 0) return 1'b0;
        if (k == 1) return 1'b1;
        if (k == 2) return (c == 17 && r == 200);
        return (((c*3 + r*5 + k*11) % 7) == 0) ^ (r == k) ^ (c == (k % 32));
    endfunction

    function automatic logic [N_COLS-1:0] exp_word(input int k, input int r);
        logic [N_COLS-1:0] w;
        for (int c = 0; c < N_COLS; c++) w[c] = pat(k, c, r);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire(input int k);
        @(negedge clk);
        for (int c = 0; c < N_COLS; c++)
            for (int r = 0; r < N_ROWS; r++) hits_i[c*N_ROWS + r] = pat(k, c, r);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        hits_i = '0;
        #1;
    endtask

    // Reads rows [from, to) of event k, checking each word before its strobe edge.
    task automatic read_rows(input int k, input int from, input int to, input string req);
        for (int r = from; r < to; r++) begin
            @(negedge clk);
            cs_i = 1'b1;
            rd_i = 1'b1;
            #1;
            check(valid_o && data_o == exp_word(k, r), req,
                  {31'd0, valid_o, data_o}, {32'd1, exp_word(k, r)});
        end
        @(negedge clk);
        cs_i = 1'b0;
        rd_i = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check(empty_o && !busy_o && !ovf_o && !valid_o && data_o == '0, "R1",
              {busy_o, empty_o, ovf_o, valid_o, data_o}, {4'b0100, 32'd0});
    endtask

    task automatic t_single;
        fire(2);
        check(!empty_o, "R9", 64'(empty_o), 64'd0);
        read_rows(2, 0, N_ROWS, "R2");
        check(empty_o, "R4", 64'(empty_o), 64'd1);
        fire(1);
        read_rows(1, 0, N_ROWS, "R2");
        fire(0);
        read_rows(0, 0, N_ROWS, "R4");
        check(empty_o, "R9", 64'(empty_o), 64'd1);
    endtask

    task automatic t_fifo;
        for (int k = 3; k < 3 + DEPTH; k++) begin
            check(!busy_o, "R6", 64'(busy_o), 64'd0);
            fire(k);
        end
        check(busy_o, "R6", 64'(busy_o), 64'd1);
        check(!ovf_o, "R7", 64'(ovf_o), 64'd0);
        fire(1);
        check(ovf_o, "R7", 64'(ovf_o), 64'd1);
        for (int k = 3; k < 3 + DEPTH; k++) begin
            read_rows(k, 0, N_ROWS, "R5");
            check(!busy_o, "R6", 64'(busy_o), 64'd0);
        end
        check(empty_o, "R7", 64'(empty_o), 64'd1);
        check(ovf_o, "R7", 64'(ovf_o), 64'd1);
    endtask

    task automatic t_chipsel;
        fire(9);
        read_rows(9, 0, 10, "R3");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cs_i = 1'b0;
            rd_i = 1'b1;
            #1;
            check(!valid_o && data_o == '0, "R8", {31'd0, valid_o, data_o}, 64'd0);
        end
        @(negedge clk);
        rd_i = 1'b0;
        read_rows(9, 10, N_ROWS, "R8");
        check(empty_o, "R4", 64'(empty_o), 64'd1);
    endtask

    task automatic t_empty_read;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cs_i = 1'b1;
            rd_i = 1'b1;
            #1;
            check(!valid_o && data_o == '0, "R9", {31'd0, valid_o, data_o}, 64'd0);
        end
        @(negedge clk);
        cs_i = 1'b0;
        rd_i = 1'b0;
        fire(12);
        read_rows(12, 0, N_ROWS, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_single();
        t_fifo();
        t_chipsel();
        t_empty_read();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule